// File: doc/BRIEF.md
# Direct-Mapped Branch Direction Predictor

This block keeps a small table of per-branch direction state. Fetch presents a program counter on the lookup port. In the same cycle the block answers whether the branch at that address is expected to be taken. When the branch later resolves, the pipeline presents its address and real outcome on the update port, and the selected entry learns from it.

The table is direct-mapped and untagged. Branches whose addresses share the same index bits share one entry.

An elaboration parameter selects the kind of entry:
- **Last-outcome mode:** each entry is a single bit that simply remembers the most recent outcome.
- **Hysteresis mode:** each entry is a two-bit saturating counter. One contrary outcome does not flip a strongly held prediction.

On a counted loop branch, the two modes give different misprediction totals.

Top module: `bpt_table`

## Requirements
- R1: The entry index is taken from PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 have no effect on which entry is read or written.
- R2: With MODE = MODE_LAST, each entry is one bit. The value 0 predicts not taken and 1 predicts taken. An update overwrites the indexed entry with the resolved outcome (1 = taken).
- R3: With MODE = MODE_HYST, each entry is a two-bit counter: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The prediction is entry bit 1. A taken update adds one and a not-taken update subtracts one.
- R4: The two-bit counter saturates. A taken update at 11 leaves 11, and a not-taken update at 00 leaves 00. It never wraps.
- R5: After reset every entry predicts not taken. In MODE_HYST every entry starts at 01, so a single taken update makes it predict taken.
- R6: A lookup and an update to the same index in the same cycle return the value held before that update. The update is visible from the next cycle.
- R7: An update changes only the entry selected by up_pc. No other entry's prediction changes.
- R8: In MODE_LAST, a loop branch that is taken 9 times and then not taken once is mispredicted twice in every execution of the loop: on its first and last evaluation.
- R9: In MODE_HYST, the same loop is mispredicted twice in its first execution after reset and once in every later execution (only the final, not-taken evaluation).
- R10: While up_valid is 0, the values on up_pc and up_taken do not change any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, combinational (1 = taken) |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The bench builds two copies of the block, both with PC_W = 32 and IDX_W = 6: one in MODE_HYST and one in MODE_LAST. Both receive the same stimulus, so every cycle compares the two entry variants against their own reference models.

The 64-entry table lets a sweep check every reset value. Random addresses confined to a few index values, with junk in the ignored bits, force aliasing, same-cycle read/write collisions and both saturation ends. A replayed ten-iteration loop exposes the different misprediction counts of the two modes.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   typedef enum logic [0:0] {
      MODE_LAST = 1'b0,
      MODE_HYST = 1'b1
   } mode_e;

   localparam logic [1:0] HYST_RESET = 2'b01;
   localparam logic [1:0] HYST_MAX   = 2'b11;
   localparam logic [1:0] HYST_MIN   = 2'b00;

   function automatic int entry_width(mode_e m);
      return (m == MODE_HYST) ? 2 : 1;
   endfunction

endpackage

// File: rtl/bpt_index.sv
module bpt_index #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 6
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   localparam int LO = 2;
   localparam int HI = IDX_W + LO - 1;

   always_comb idx = pc[HI:LO];
endmodule

// File: rtl/bpt_entry.sv
module bpt_entry
   import bpt_pkg::*;
#(
   parameter mode_e MODE = MODE_HYST
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic taken,
   output logic pred
);
   localparam int EW = entry_width(MODE);

   logic [EW-1:0] st;

   generate
      if (MODE == MODE_HYST) begin : g_hyst
         always_ff @(posedge clk) begin
            if (!rst_n)
               st <= HYST_RESET;
            else if (wr) begin
               if (taken && st != HYST_MAX)
                  st <= st + 2'd1;
               else if (!taken && st != HYST_MIN)
                  st <= st - 2'd1;
            end
         end
         always_comb pred = st[1];

         assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && taken && st == HYST_MAX) |=> (st == HYST_MAX));
         assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !taken && st == HYST_MIN) |=> (st == HYST_MIN));
         assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && taken && st != HYST_MAX) |=> (st == $past(st) + 2'd1));
         assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !taken && st != HYST_MIN) |=> (st == $past(st) - 2'd1));
      end else begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n)
               st <= 1'b0;
            else if (wr)
               st <= taken;
         end
         always_comb pred = st[0];

         assert_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr |=> (st[0] == $past(taken)));
      end
   endgenerate

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(st));
endmodule

// File: rtl/bpt_table.sv
module bpt_table
   import bpt_pkg::*;
#(
   parameter int    PC_W  = 32,
   parameter int    IDX_W = 6,
   parameter mode_e MODE  = MODE_HYST
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 12 || IDX_W + 2 > PC_W) begin : g_bad_cfg
         $error("bpt_table: IDX_W must be 1..12 and fit inside PC_W above bit 1");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   logic [DEPTH-1:0] pred_vec;

   bpt_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (.pc(lk_pc), .idx(lk_idx));
   bpt_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (.pc(up_pc), .idx(up_idx));

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic wr_i;
         always_comb wr_i = up_valid && (up_idx == IDX_W'(i));
         bpt_entry #(.MODE(MODE)) u_ent (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (wr_i),
            .taken(up_taken),
            .pred (pred_vec[i])
         );
      end
   endgenerate

   always_comb lk_taken = pred_vec[lk_idx];

   // R1: whole addresses must be defined when used; low and high bits only alias
   assert_lk_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(lk_pc));
   assert_up_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> !$isunknown({up_pc, up_taken}));
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(pred_vec));
endmodule

// File: tb/sim_bpt_table.sv
module sim_bpt_table;
   import bpt_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W  = 32;
   localparam int IDX_W = 6;
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [PC_W-1:0] LOOP_PC = 32'h0000_1A34;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0;
   logic [PC_W-1:0] up_pc = '0;
   logic up_valid = 1'b0;
   logic up_taken = 1'b0;
   logic lk_h, lk_l;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0] m_hyst [DEPTH];
   logic       m_last [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   bpt_table #(.PC_W(PC_W), .IDX_W(IDX_W), .MODE(MODE_HYST)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_h),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));
   bpt_table #(.PC_W(PC_W), .IDX_W(IDX_W), .MODE(MODE_LAST)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_l),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

   function automatic int idx_of(logic [PC_W-1:0] pc);
      return int'(pc[IDX_W+1:2]);
   endfunction

   function automatic logic [1:0] hyst_next(logic [1:0] s, logic t);
      if (t) return (s == 2'b11) ? s : s + 2'd1;
      return (s == 2'b00) ? s : s - 2'd1;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_hyst[i] = 2'b01;
         m_last[i] = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; up_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // drive at negedge, check combinational prediction, then let the edge update
   task automatic cycle(string tag, logic [PC_W-1:0] lpc, logic uv,
                        logic [PC_W-1:0] upc, logic ut);
      @(negedge clk);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
      #1;
      check({tag, " hyst"}, int'(lk_h), int'(m_hyst[idx_of(lpc)][1]));
      check({tag, " last"}, int'(lk_l), int'(m_last[idx_of(lpc)]));
      if (uv) begin
         m_hyst[idx_of(upc)] = hyst_next(m_hyst[idx_of(upc)], ut);
         m_last[idx_of(upc)] = ut;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int mis_h, mis_l;
      void'($urandom(32'd20240611));
      do_reset();

      // R5: every entry predicts not taken after reset
      for (int i = 0; i < DEPTH; i++)
         cycle("R5 reset sweep", PC_W'(i) << 2, 1'b0, '0, 1'b0);

      // R5 / R3: weak not-taken start flips with one taken update
      cycle("R5 first update", 32'h40, 1'b1, 32'h40, 1'b1);
      cycle("R5 after one taken", 32'h40, 1'b0, '0, 1'b0);
      check("R5 hyst flips after one taken", int'(lk_h), 1);

      // R6: same-index lookup and update see the old value
      cycle("R6 collide", 32'h40, 1'b1, 32'h40, 1'b0);
      cycle("R6 visible next cycle", 32'h40, 1'b0, '0, 1'b0);

      // R4: saturate high then one not-taken stays taken in hysteresis mode
      for (int k = 0; k < 5; k++) cycle("R4 push high", 32'h80, 1'b1, 32'h80, 1'b1);
      cycle("R4 one not taken", 32'h80, 1'b1, 32'h80, 1'b0);
      cycle("R4 after high", 32'h80, 1'b0, '0, 1'b0);
      check("R4 hyst still taken", int'(lk_h), 1);
      check("R2 last follows outcome", int'(lk_l), 0);
      for (int k = 0; k < 5; k++) cycle("R4 push low", 32'h84, 1'b1, 32'h84, 1'b0);
      cycle("R4 one taken", 32'h84, 1'b1, 32'h84, 1'b1);
      cycle("R4 after low", 32'h84, 1'b0, '0, 1'b0);
      check("R4 hyst still not taken", int'(lk_h), 0);
      check("R2 last follows outcome", int'(lk_l), 1);

      // R1: ignored low/high bits alias onto the same entry
      cycle("R1 alias write", 32'h0000_00C0, 1'b1, 32'hFFFF_F0C3, 1'b1);
      cycle("R1 alias read", 32'h1234_50C1, 1'b0, '0, 1'b0);
      check("R1 aliased read hyst", int'(lk_h), 1);

      // R10: idle strobe with junk update data
      for (int k = 0; k < 20; k++)
         cycle("R10 idle", PC_W'($urandom_range(0, 7)) << 2, 1'b0,
               $urandom(), 1'(k));

      // R2 R3 R7: random traffic on a few entries, junk in ignored bits
      for (int k = 0; k < 400; k++) begin
         logic [PC_W-1:0] a, b;
         a = {PC_W'($urandom()) & ~PC_W'(32'hFF)} | (PC_W'($urandom_range(0, 7)) << 2)
             | PC_W'($urandom_range(0, 3));
         b = (k % 5 == 0) ? a
             : ({PC_W'($urandom()) & ~PC_W'(32'hFF)} | (PC_W'($urandom_range(0, 7)) << 2));
         cycle("R3 R2 R7 random", a, 1'($urandom_range(0, 3) != 0), b,
               1'($urandom_range(0, 1)));
      end

      // R8 R9: counted loop replay
      do_reset();
      for (int run = 0; run < 4; run++) begin
         mis_h = 0; mis_l = 0;
         for (int it = 0; it < 10; it++) begin
            logic t;
            t = (it < 9);
            cycle("R8 R9 loop", LOOP_PC, 1'b1, LOOP_PC, t);
            if (lk_h != t) mis_h++;
            if (lk_l != t) mis_l++;
         end
         check("R8 last-mode loop mispredicts", mis_l, 2);
         check("R9 hyst-mode loop mispredicts", mis_h, (run == 0) ? 2 : 1);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule